// File: doc/BRIEF.md
# USB Low/Full-Speed Receive Front End

This block turns the sampled D+/D- line levels of a low-speed or full-speed USB link into a parallel receive stream. It runs from a clock four times the bit rate (48 MHz for full speed, 6 MHz for low speed). A digital phase tracker re-centres its sampling point on every line transition, so the block follows a transmitter whose bit rate drifts from nominal. Each recovered symbol goes through packet framing, NRZI decoding and stuffed-bit removal. Data bits are then packed least-significant bit first into words of 8 or 16 bits.

A protocol engine above the block watches `rx_active` to see a packet in progress and takes a word on each `rx_valid` pulse. It is told the reason when a packet dies through one of three error pulses: a stuffing violation, a packet that ends part-way through a word, or a broken SYNC or end-of-packet pattern. After any error the block drops the rest of the packet. It waits for the next end-of-packet signalling before it looks for a new SYNC.

Top module: `usbrx_frontend`

## Requirements
- R1: After reset, `rx_active`, `rx_valid`, `rx_err_stuff`, `rx_err_align` and `rx_err_sync` are all low, and they stay low while the line sits idle in J.
- R2: Line decoding: both lines low is SE0. At full speed (`LOW_SPEED`=0), D+ high with D- low is J and the reverse is K. At low speed (`LOW_SPEED`=1), J and K swap. A low-speed instance fed the mirrored lines therefore gives outputs identical to a full-speed instance.
- R3: The symbol sequence K J K J K J K K raises `rx_active`. Each later bit is NRZI-decoded: an unchanged line state gives 1 and a change gives 0. The bits are packed LSB first, so the first bit received lands in `rx_data[0]`. `rx_valid` pulses for one cycle per completed word, and only while `rx_active` is high.
- R4: After six 1s in a row, the next bit is discarded if it is 0. The final 1 of SYNC counts toward this run. If that bit is a 1 instead, `rx_err_stuff` pulses, `rx_active` falls, and no further words are delivered for the packet.
- R5: SE0 for two bit times followed by J ends the packet. `rx_active` falls and no error is raised when the bit count is a whole number of words.
- R6: If the end of packet arrives with a partial word collected, `rx_err_align` pulses and the partial bits are never delivered.
- R7: `rx_err_sync` pulses in three cases, and `rx_active` is not raised or is dropped: an unchanged line state before the last SYNC position; a non-J/K state during SYNC; or an SE0 lasting a single bit, or ended by K, inside a packet.
- R8: Packets whose bit period drifts to 3.9 or 4.1 samples decode the same as at the nominal 4 samples. The sampling phase re-locks on every line transition.
- R9: With `DATA_W`=16, bytes are paired into one word with the first byte in bits 7:0, and `rx_valid` pulses once per 16-bit word.
- R10: Error outputs are one-cycle pulses, never more than one at a time, and `rx_active` is low in the cycle of any error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 4x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| rx_data | output | DATA_W | Received word, valid while `rx_valid` is high |
| rx_valid | output | 1 | One-cycle pulse per completed word |
| rx_active | output | 1 | High from SYNC detection until end of packet or error |
| rx_err_stuff | output | 1 | Bit-stuffing violation pulse |
| rx_err_align | output | 1 | End of packet on a partial word pulse |
| rx_err_sync | output | 1 | Broken SYNC or end-of-packet pattern pulse |

## Verification
Clean packets with mixed byte values are sent at nominal, slow and fast bit periods. The drifted runs show whether the phase tracker re-locks, because a wrong sample point would corrupt bytes rather than raise an error. Runs of 0xFF bytes separate correct stuffed-bit removal from an off-by-one run count. Raw seven-1 runs, packets cut mid-word, SYNC patterns with a repeated K or an early SE0, and single-bit SE0 endings each have to raise exactly one of the three error pulses. The 8-bit, 16-bit and mirrored low-speed instances receive the same line, which exposes lane ordering and J/K polarity faults.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  typedef enum logic [1:0] {
    SYM_SE0 = 2'd0,
    SYM_J   = 2'd1,
    SYM_K   = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [2:0] {
    DS_IDLE,
    DS_SYNC,
    DS_DATA,
    DS_EOP1,
    DS_EOP2,
    DS_SKIP,
    DS_SKIP_E
  } dec_state_e;

  localparam int unsigned SYNC_LEN  = 8;
  localparam int unsigned STUFF_RUN = 6;

endpackage

// File: rtl/usbrx_dpll.sv
module usbrx_dpll
  import usbrx_pkg::*;
#(
  parameter bit          LOW_SPEED  = 1'b0,
  parameter int unsigned OVERSAMPLE = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_dp,
  input  logic      line_dm,
  output logic      strobe_o,
  output line_sym_e sym_o
);

  localparam int unsigned PH_W      = $clog2(OVERSAMPLE);
  localparam int unsigned SAMPLE_PH = OVERSAMPLE / 2;

  line_sym_e       sym_in;
  line_sym_e       sym_q;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            edge_seen;

  // line state map; low speed swaps the idle polarity
  always_comb begin
    unique case ({line_dp, line_dm})
      2'b00:   sym_in = SYM_SE0;
      2'b11:   sym_in = SYM_SE1;
      2'b10:   sym_in = LOW_SPEED ? SYM_K : SYM_J;
      default: sym_in = LOW_SPEED ? SYM_J : SYM_K;
    endcase
  end

  assign edge_seen = (sym_in != sym_q);

  always_comb begin
    if (edge_seen) begin
      ph_d = PH_W'(1);
    end else if (ph_q == PH_W'(OVERSAMPLE - 1)) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= SYM_J;
      ph_q  <= '0;
    end else begin
      sym_q <= sym_in;
      ph_q  <= ph_d;
    end
  end

  assign strobe_o = (ph_q == PH_W'(SAMPLE_PH));
  assign sym_o    = sym_q;

  // R8
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

endmodule

// File: rtl/usbrx_decoder.sv
module usbrx_decoder
  import usbrx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_i,
  input  line_sym_e sym_i,
  output logic      sop_o,
  output logic      bit_vld_o,
  output logic      bit_o,
  output logic      eop_o,
  output logic      abort_o,
  output logic      err_stuff_o,
  output logic      err_sync_o
);

  localparam logic [2:0] SYNC_LAST = 3'(SYNC_LEN - 1);
  localparam logic [2:0] RUN_MAX   = 3'(STUFF_RUN);

  dec_state_e st_q, st_d;
  line_sym_e  prev_q, prev_d;
  logic [2:0] cnt_q, cnt_d;
  logic [2:0] ones_q, ones_d;
  logic       sop_d, bv_d, bit_d, eop_d, abort_d, estf_d, esyn_d;
  logic       same;
  logic       is_jk;

  assign same  = (sym_i == prev_q);
  assign is_jk = (sym_i == SYM_J) || (sym_i == SYM_K);

  always_comb begin
    st_d    = st_q;
    prev_d  = prev_q;
    cnt_d   = cnt_q;
    ones_d  = ones_q;
    sop_d   = 1'b0;
    bv_d    = 1'b0;
    bit_d   = 1'b0;
    eop_d   = 1'b0;
    abort_d = 1'b0;
    estf_d  = 1'b0;
    esyn_d  = 1'b0;
    if (strobe_i) begin
      prev_d = sym_i;
      unique case (st_q)
        DS_IDLE: begin
          if (sym_i == SYM_K) begin
            st_d  = DS_SYNC;
            cnt_d = 3'd1;
          end
        end
        DS_SYNC: begin
          if (!is_jk) begin
            esyn_d = 1'b1;
            st_d   = DS_IDLE;
          end else if (cnt_q != SYNC_LAST) begin
            if (same) begin
              esyn_d = 1'b1;
              st_d   = DS_IDLE;
            end else begin
              cnt_d = cnt_q + 3'd1;
            end
          end else if (same) begin
            sop_d  = 1'b1;
            st_d   = DS_DATA;
            ones_d = 3'd1;
          end else begin
            esyn_d = 1'b1;
            st_d   = DS_IDLE;
          end
        end
        DS_DATA: begin
          if (sym_i == SYM_SE0) begin
            st_d = DS_EOP1;
          end else if (sym_i == SYM_SE1) begin
            esyn_d  = 1'b1;
            abort_d = 1'b1;
            st_d    = DS_SKIP;
          end else if (ones_q == RUN_MAX) begin
            if (same) begin
              estf_d  = 1'b1;
              abort_d = 1'b1;
              st_d    = DS_SKIP;
            end else begin
              ones_d = 3'd0;
            end
          end else begin
            bv_d   = 1'b1;
            bit_d  = same;
            ones_d = same ? ones_q + 3'd1 : 3'd0;
          end
        end
        DS_EOP1: begin
          if (sym_i == SYM_SE0) begin
            st_d = DS_EOP2;
          end else begin
            esyn_d  = 1'b1;
            abort_d = 1'b1;
            st_d    = (sym_i == SYM_J) ? DS_IDLE : DS_SKIP;
          end
        end
        DS_EOP2: begin
          if (sym_i == SYM_J) begin
            eop_d = 1'b1;
            st_d  = DS_IDLE;
          end else if (sym_i != SYM_SE0) begin
            esyn_d  = 1'b1;
            abort_d = 1'b1;
            st_d    = DS_SKIP;
          end
        end
        DS_SKIP: begin
          if (sym_i == SYM_SE0) st_d = DS_SKIP_E;
        end
        DS_SKIP_E: begin
          if (sym_i == SYM_J)      st_d = DS_IDLE;
          else if (sym_i == SYM_K) st_d = DS_SKIP;
        end
        default: st_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= DS_IDLE;
      prev_q      <= SYM_J;
      cnt_q       <= '0;
      ones_q      <= '0;
      sop_o       <= 1'b0;
      bit_vld_o   <= 1'b0;
      bit_o       <= 1'b0;
      eop_o       <= 1'b0;
      abort_o     <= 1'b0;
      err_stuff_o <= 1'b0;
      err_sync_o  <= 1'b0;
    end else begin
      st_q        <= st_d;
      prev_q      <= prev_d;
      cnt_q       <= cnt_d;
      ones_q      <= ones_d;
      sop_o       <= sop_d;
      bit_vld_o   <= bv_d;
      bit_o       <= bit_d;
      eop_o       <= eop_d;
      abort_o     <= abort_d;
      err_stuff_o <= estf_d;
      err_sync_o  <= esyn_d;
    end
  end

  // R4
  ones_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DS_DATA) |-> (ones_q <= RUN_MAX));

  // R3
  sop_enters_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sop_o |-> (st_q == DS_DATA));

endmodule

// File: rtl/usbrx_deser.sv
module usbrx_deser #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              eop_i,
  input  logic              abort_i,
  input  logic              stuff_err_i,
  input  logic              sync_err_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              active_o,
  output logic              err_stuff_o,
  output logic              err_align_o,
  output logic              err_sync_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic              act_q, act_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic [DATA_W-1:0] data_q;
  logic              vld_d, ealn_d;
  logic              shift_en;

  assign shift_en = act_q && bit_vld_i && !sop_i;
  assign shf_d    = {bit_i, shf_q[DATA_W-1:1]};

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    ealn_d = 1'b0;
    if (sop_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (bit_vld_i) begin
        if (cnt_q == CNT_LAST) begin
          vld_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      if (eop_i) begin
        act_d  = 1'b0;
        ealn_d = (cnt_q != '0);
      end
      if (abort_i) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      cnt_q       <= '0;
      shf_q       <= '0;
      data_q      <= '0;
      valid_o     <= 1'b0;
      err_align_o <= 1'b0;
      err_stuff_o <= 1'b0;
      err_sync_o  <= 1'b0;
    end else begin
      act_q       <= act_d;
      cnt_q       <= cnt_d;
      valid_o     <= vld_d;
      err_align_o <= ealn_d;
      err_stuff_o <= stuff_err_i;
      err_sync_o  <= sync_err_i;
      if (shift_en) shf_q  <= shf_d;
      if (vld_d)    data_q <= shf_d;
    end
  end

  assign data_o   = data_q;
  assign active_o = act_q;

  // R3
  valid_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> active_o);

  // R10
  err_ends_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stuff_o || err_align_o || err_sync_o) |-> !active_o);

  // R6
  align_after_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_align_o |-> $past(act_q));

endmodule

// File: rtl/usbrx_frontend.sv
module usbrx_frontend
  import usbrx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter bit          LOW_SPEED  = 1'b0,
  parameter int unsigned OVERSAMPLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dp,
  input  logic              line_dm,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_err_stuff,
  output logic              rx_err_align,
  output logic              rx_err_sync
);

  logic      rst_q1, rst_q2;
  logic      rst_n_int;
  logic      strobe;
  line_sym_e sym;
  logic      sop, bit_vld, bit_val, eop, abort, estf, esyn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  assign rst_n_int = rst_q2;

  usbrx_dpll #(
    .LOW_SPEED  (LOW_SPEED),
    .OVERSAMPLE (OVERSAMPLE)
  ) dpll_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .line_dp  (line_dp),
    .line_dm  (line_dm),
    .strobe_o (strobe),
    .sym_o    (sym)
  );

  usbrx_decoder dec_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .strobe_i    (strobe),
    .sym_i       (sym),
    .sop_o       (sop),
    .bit_vld_o   (bit_vld),
    .bit_o       (bit_val),
    .eop_o       (eop),
    .abort_o     (abort),
    .err_stuff_o (estf),
    .err_sync_o  (esyn)
  );

  usbrx_deser #(
    .DATA_W (DATA_W)
  ) deser_i (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sop_i       (sop),
    .bit_vld_i   (bit_vld),
    .bit_i       (bit_val),
    .eop_i       (eop),
    .abort_i     (abort),
    .stuff_err_i (estf),
    .sync_err_i  (esyn),
    .data_o      (rx_data),
    .valid_o     (rx_valid),
    .active_o    (rx_active),
    .err_stuff_o (rx_err_stuff),
    .err_align_o (rx_err_align),
    .err_sync_o  (rx_err_sync)
  );

  // R10
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({rx_err_stuff, rx_err_align, rx_err_sync}));

endmodule

// File: tb/usbrx_frontend_tb_top.sv
module usbrx_frontend_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int L_SE0 = 0;
  localparam int L_J   = 1;
  localparam int L_K   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b1;
  logic dm = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  d8, dls;
  logic [15:0] d16;
  logic v8, a8, es8, ea8, ey8;
  logic v16, a16, es16, ea16, ey16;
  logic vls, als, esls, eals, eyls;

  usbrx_frontend #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_dp(dp), .line_dm(dm),
    .rx_data(d8), .rx_valid(v8), .rx_active(a8),
    .rx_err_stuff(es8), .rx_err_align(ea8), .rx_err_sync(ey8));

  usbrx_frontend #(.DATA_W(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .line_dp(dp), .line_dm(dm),
    .rx_data(d16), .rx_valid(v16), .rx_active(a16),
    .rx_err_stuff(es16), .rx_err_align(ea16), .rx_err_sync(ey16));

  usbrx_frontend #(.DATA_W(8), .LOW_SPEED(1'b1)) dutls_i (
    .clk(clk), .rst_n(rst_n), .line_dp(dm), .line_dm(dp),
    .rx_data(dls), .rx_valid(vls), .rx_active(als),
    .rx_err_stuff(esls), .rx_err_align(eals), .rx_err_sync(eyls));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  int  q8[$];
  int  q16[$];
  int  got_err8, got_err16;
  int  e8, e16;
  bit  act_seen, ls_bad, err_act_bad, mon_on;

  always @(negedge clk) begin
    if (mon_on) begin
      if (v8) begin
        if (q8.size() == 0) chk(1'b0, "R3 unexpected byte", int'(d8), -1);
        else begin
          e8 = q8.pop_front();
          chk(int'(d8) == e8, "R3 byte value", int'(d8), e8);
        end
      end
      if (v16) begin
        if (q16.size() == 0) chk(1'b0, "R9 unexpected word", int'(d16), -1);
        else begin
          e16 = q16.pop_front();
          chk(int'(d16) == e16, "R9 word value", int'(d16), e16);
        end
      end
      if (es8 | ea8 | ey8) begin
        got_err8 = es8 ? 1 : (ea8 ? 2 : 3);
        if (a8 || (int'(es8) + int'(ea8) + int'(ey8)) > 1) err_act_bad = 1'b1;
      end
      if (es16 | ea16 | ey16) begin
        got_err16 = es16 ? 1 : (ea16 ? 2 : 3);
        if (a16) err_act_bad = 1'b1;
      end
      if (a8) act_seen = 1'b1;
      if ({dls, vls, als, esls, eals, eyls} != {d8, v8, a8, es8, ea8, ey8}) ls_bad = 1'b1;
    end
  end

  // line stimulus with drifting bit period (tenths of a sample)
  int period10 = 40;
  int acc = 0;
  int done_s = 0;
  int run = 0;
  bit bq[$];

  task automatic drive_sym(input int s);
    int n;
    case (s)
      L_SE0:   {dp, dm} = 2'b00;
      L_J:     {dp, dm} = 2'b10;
      default: {dp, dm} = 2'b01;
    endcase
    acc += period10;
    n = acc / 10 - done_s;
    done_s += n;
    repeat (n) @(negedge clk);
  endtask

  task automatic push_bit(input bit b);
    bq.push_back(b);
    if (b) run++; else run = 0;
    if (run == 6) begin
      bq.push_back(1'b0);
      run = 0;
    end
  endtask

  task automatic push_byte(input int b);
    for (int i = 0; i < 8; i++) push_bit(b[i]);
  endtask

  task automatic start_pkt();
    bq.delete();
    for (int i = 0; i < 7; i++) bq.push_back(1'b0);
    bq.push_back(1'b1);
    run = 1;
  endtask

  task automatic emit_bits();
    int lvl;
    lvl = L_J;
    foreach (bq[i]) begin
      if (!bq[i]) lvl = 3 - lvl;
      drive_sym(lvl);
    end
    bq.delete();
  endtask

  task automatic end_pkt(input int se0_bits);
    for (int i = 0; i < se0_bits; i++) drive_sym(L_SE0);
    for (int i = 0; i < 6; i++) drive_sym(L_J);
  endtask

  task automatic expect_bytes(input int b[$]);
    foreach (b[i]) q8.push_back(b[i]);
    for (int i = 0; i + 1 < b.size(); i += 2) q16.push_back(b[i] | (b[i+1] << 8));
  endtask

  task automatic close_pkt(input string tag, input int x8, input int x16, input bit xact);
    repeat (4) @(negedge clk);
    chk(q8.size() == 0, {tag, " 8-bit words all delivered"}, q8.size(), 0);
    chk(q16.size() == 0, {tag, " 16-bit words all delivered"}, q16.size(), 0);
    chk(got_err8 == x8, {tag, " 8-bit error kind"}, got_err8, x8);
    chk(got_err16 == x16, {tag, " 16-bit error kind"}, got_err16, x16);
    chk(act_seen == xact, {tag, " rx_active raised"}, int'(act_seen), int'(xact));
    chk(!a8 && !a16, {tag, " R5 rx_active low after packet"}, int'(a8), 0);
    chk(!ls_bad, {tag, " R2 low-speed mirror matches"}, int'(ls_bad), 0);
    chk(!err_act_bad, {tag, " R10 error pulse exclusive and outside packet"}, int'(err_act_bad), 0);
    q8.delete();
    q16.delete();
    got_err8 = 0;
    got_err16 = 0;
    act_seen = 1'b0;
    ls_bad = 1'b0;
    err_act_bad = 1'b0;
  endtask

  task automatic data_pkt(input int b[$], input string tag, input int x16);
    start_pkt();
    foreach (b[i]) push_byte(b[i]);
    expect_bytes(b);
    emit_bits();
    end_pkt(2);
    close_pkt(tag, 0, x16, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    got_err8 = 0; got_err16 = 0; act_seen = 0; ls_bad = 0; err_act_bad = 0; mon_on = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk({v8, a8, es8, ea8, ey8, v16, a16, es16, ea16, ey16} == '0,
        "R1 outputs idle after reset", int'({v8, a8, es8, ea8, ey8}), 0);
    mon_on = 1'b1;
    for (int i = 0; i < 8; i++) drive_sym(L_J);
    close_pkt("R1 idle line", 0, 0, 1'b0);

    // R3 R5 R9 plain packet
    data_pkt('{8'hA5, 8'h3C}, "R3 R9 two bytes", 0);
    // R4 stuffing removal, odd length gives R6 on 16-bit
    data_pkt('{8'hFF, 8'hFF, 8'h7E}, "R4 stuffed run", 2);
    // R8 drift slow and fast
    period10 = 39;
    data_pkt('{8'h00, 8'hFF, 8'h81, 8'h42, 8'hC3}, "R8 period 3.9", 2);
    period10 = 41;
    data_pkt('{8'h00, 8'hFF, 8'h81, 8'h42, 8'hC3}, "R8 period 4.1", 2);
    period10 = 40;
    // R5 empty packet
    start_pkt();
    emit_bits();
    end_pkt(2);
    close_pkt("R5 empty packet", 0, 0, 1'b1);

    // R6 partial word at end of packet
    start_pkt();
    push_byte(8'h5A);
    push_bit(1'b1); push_bit(1'b0); push_bit(1'b1); push_bit(1'b0);
    q8.push_back(8'h5A);
    emit_bits();
    end_pkt(2);
    close_pkt("R6 partial word", 2, 2, 1'b1);

    // R4 seventh one is a stuffing error
    start_pkt();
    push_byte(8'h00);
    for (int i = 0; i < 7; i++) bq.push_back(1'b1);
    bq.push_back(1'b0); bq.push_back(1'b1); bq.push_back(1'b0);
    q8.push_back(8'h00);
    emit_bits();
    end_pkt(2);
    close_pkt("R4 stuffing violation", 1, 1, 1'b1);

    // R7 repeated K inside SYNC
    drive_sym(L_K); drive_sym(L_J); drive_sym(L_K); drive_sym(L_K);
    for (int i = 0; i < 6; i++) drive_sym(L_J);
    close_pkt("R7 broken SYNC", 3, 3, 1'b0);

    // R7 SE0 inside SYNC
    drive_sym(L_K); drive_sym(L_J); drive_sym(L_SE0); drive_sym(L_SE0);
    for (int i = 0; i < 6; i++) drive_sym(L_J);
    close_pkt("R7 SE0 in SYNC", 3, 3, 1'b0);

    // R7 single-bit SE0 end
    start_pkt();
    push_byte(8'h3C);
    q8.push_back(8'h3C);
    emit_bits();
    end_pkt(1);
    close_pkt("R7 short SE0", 3, 3, 1'b1);

    // recovery after errors
    data_pkt('{8'h12, 8'h34, 8'hE7, 8'h80}, "R3 R9 after errors", 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule